// File: doc/BRIEF.md
# Lockable Thermal Trip Register Bank

This block is the software-facing control for an on-die temperature monitor. Firmware programs three settings through a small register port: a trip threshold in degrees, a calibration slope, and an enable for the hardware shutdown response. A raw digital reading from the sensor is scaled by the slope into degrees and held in a read-only register. When the response is enabled and that temperature is at or above the threshold, the block raises a registered shutdown request for the power-sequencing logic.

After boot, firmware sets a one-way guard bit. From then until the next reset, every setting that takes part in detection or response is frozen. That covers the threshold, the slope and the enable. This means no later software can defeat the trip by lowering the calibration or clearing the enable, which it could do if only the threshold were guarded.

The register port is single-cycle: a write happens on the clock edge where `bus_we` is high. Read data is registered and shows the register selected by `bus_addr` in the previous cycle.

Top module: `therm_guard`

## Requirements
- R1: After a synchronous reset, the threshold reads 125, the slope reads 25, and the guard, enable, current temperature and `shutdown_req` are all 0.
- R2: The threshold register at offset 0x00 stores write data bits [7:0]. Bits [31:8] always read 0.
- R3: The slope register at offset 0x04 stores all 32 bits of write data while unguarded.
- R4: The guard is bit 0 at offset 0x08. Writing 1 sets it. Writing 0 leaves it unchanged. Once set, only reset clears it. Bits [31:1] read 0.
- R5: While the guard is set, writes to the threshold, the slope and the enable are ignored, and all three keep their values.
- R6: A protected write in the cycle right after the guard-setting write is rejected.
- R7: When `raw_valid` is high, the current temperature becomes (raw × slope) >> 4, computed at full width and clipped to 255. Otherwise it holds its value.
- R8: The current temperature is read at offset 0x10 in bits [7:0]. Writes to that offset have no effect.
- R9: `shutdown_req` is registered. One cycle after the condition, it equals (enable = 1 and current temperature ≥ threshold). The enable is bit 1 at offset 0x0C, and the other bits of that register read 0.
- R10: Reads of any offset other than 0x00, 0x04, 0x08, 0x0C and 0x10 return 0. Writes to such offsets change nothing.
- R11: `bus_rdata` shows the register that was addressed one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for this cycle |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| raw_in | input | 12 | Raw sensor reading |
| raw_valid | input | 1 | Sample strobe for `raw_in` |
| shutdown_req | output | 1 | Registered shutdown request |

## Verification
The bench targets three failure modes:
- **Incomplete guard.** A design that guards only the threshold would let the post-guard writes to the slope and the enable show up on readback.
- **Lock timing.** A guard that acts one cycle late would accept the write issued right after locking.
- **Wrong guard-write handling.** A design that treats a 0 write to the guard as a clear would reopen the bank.

For conversion, the bench checks:
- products that only just reach 255;
- products above 255, including one whose overflow lies far above bit 7, which a design that truncates instead of clipping would get wrong;
- products that truncate to 0.

It also checks that the trip output lags the temperature by exactly one cycle, that it fires on equality (a strict compare would miss this), and that the mirror and unmapped offsets neither store nor alias writes.

// File: rtl/therm_guard_pkg.sv
package therm_guard_pkg;

  localparam logic [31:0] OFS_LIMIT = 32'h00;
  localparam logic [31:0] OFS_SLOPE = 32'h04;
  localparam logic [31:0] OFS_GUARD = 32'h08;
  localparam logic [31:0] OFS_RESP  = 32'h0C;
  localparam logic [31:0] OFS_TEMP  = 32'h10;

  localparam int GUARD_BIT = 0;
  localparam int RESP_BIT  = 1;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_LIMIT,
    SEL_SLOPE,
    SEL_GUARD,
    SEL_RESP,
    SEL_TEMP
  } reg_sel_e;

  function automatic reg_sel_e decode_ofs(input logic [31:0] a);
    case (a)
      OFS_LIMIT: decode_ofs = SEL_LIMIT;
      OFS_SLOPE: decode_ofs = SEL_SLOPE;
      OFS_GUARD: decode_ofs = SEL_GUARD;
      OFS_RESP:  decode_ofs = SEL_RESP;
      OFS_TEMP:  decode_ofs = SEL_TEMP;
      default:   decode_ofs = SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/therm_guard_regs.sv
module therm_guard_regs
  import therm_guard_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 8,
  parameter int TEMP_W    = 8,
  parameter int LIMIT_RST = 125,
  parameter int SLOPE_RST = 25
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [TEMP_W-1:0] cur_temp,
  output logic [TEMP_W-1:0] limit_q,
  output logic [DATA_W-1:0] slope_q,
  output logic              resp_en_q,
  output logic              guard_q
);

  reg_sel_e          sel;
  logic              prot_wr;
  logic [DATA_W-1:0] rd_mux;

  assign sel     = decode_ofs(32'(bus_addr));
  // Every control that shapes detection or response shares the one guard.
  assign prot_wr = bus_we && !guard_q;

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_LIMIT: rd_mux[TEMP_W-1:0] = limit_q;
      SEL_SLOPE: rd_mux             = slope_q;
      SEL_GUARD: rd_mux[GUARD_BIT]  = guard_q;
      SEL_RESP:  rd_mux[RESP_BIT]   = resp_en_q;
      SEL_TEMP:  rd_mux[TEMP_W-1:0] = cur_temp;
      default:   rd_mux             = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      guard_q   <= 1'b0;
      limit_q   <= TEMP_W'(LIMIT_RST);
      slope_q   <= DATA_W'(SLOPE_RST);
      resp_en_q <= 1'b0;
      bus_rdata <= '0;
    end else begin
      if (bus_we && sel == SEL_GUARD && bus_wdata[GUARD_BIT])
        guard_q <= 1'b1;
      if (prot_wr && sel == SEL_LIMIT)
        limit_q <= bus_wdata[TEMP_W-1:0];
      if (prot_wr && sel == SEL_SLOPE)
        slope_q <= bus_wdata;
      if (prot_wr && sel == SEL_RESP)
        resp_en_q <= bus_wdata[RESP_BIT];
      bus_rdata <= rd_mux;
    end
  end

endmodule

// File: rtl/therm_guard_conv.sv
module therm_guard_conv #(
  parameter int RAW_W   = 12,
  parameter int SLOPE_W = 32,
  parameter int TEMP_W  = 8,
  parameter int FRAC_SH = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [RAW_W-1:0]   raw_in,
  input  logic               raw_valid,
  input  logic [SLOPE_W-1:0] slope,
  output logic [TEMP_W-1:0]  cur_temp
);

  localparam int PROD_W = RAW_W + SLOPE_W;

  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] scaled;
  logic [TEMP_W-1:0] clipped;

  assign prod   = PROD_W'(raw_in) * PROD_W'(slope);
  assign scaled = prod >> FRAC_SH;

  generate
    if (PROD_W > TEMP_W) begin : g_clip
      assign clipped = (|scaled[PROD_W-1:TEMP_W]) ? {TEMP_W{1'b1}}
                                                  : scaled[TEMP_W-1:0];
    end else begin : g_noclip
      assign clipped = TEMP_W'(scaled);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)            cur_temp <= '0;
    else if (raw_valid) cur_temp <= clipped;
  end

endmodule

// File: rtl/therm_guard_trip.sv
module therm_guard_trip #(
  parameter int TEMP_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              resp_en,
  input  logic [TEMP_W-1:0] cur_temp,
  input  logic [TEMP_W-1:0] limit,
  output logic              shutdown_req
);

  always_ff @(posedge clk) begin
    if (rst) shutdown_req <= 1'b0;
    else     shutdown_req <= resp_en && (cur_temp >= limit);
  end

endmodule

// File: rtl/therm_guard.sv
module therm_guard #(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 8,
  parameter int RAW_W     = 12,
  parameter int TEMP_W    = 8,
  parameter int FRAC_SH   = 4,
  parameter int LIMIT_RST = 125,
  parameter int SLOPE_RST = 25
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [RAW_W-1:0]  raw_in,
  input  logic              raw_valid,
  output logic              shutdown_req
);

  logic [TEMP_W-1:0] limit_q;
  logic [DATA_W-1:0] slope_q;
  logic              resp_en_q;
  logic              guard_q;
  logic [TEMP_W-1:0] cur_temp_q;

  therm_guard_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .TEMP_W(TEMP_W),
    .LIMIT_RST(LIMIT_RST), .SLOPE_RST(SLOPE_RST)
  ) u_regs (
    .clk(clk), .rst(rst),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cur_temp(cur_temp_q),
    .limit_q(limit_q), .slope_q(slope_q),
    .resp_en_q(resp_en_q), .guard_q(guard_q)
  );

  therm_guard_conv #(
    .RAW_W(RAW_W), .SLOPE_W(DATA_W), .TEMP_W(TEMP_W), .FRAC_SH(FRAC_SH)
  ) u_conv (
    .clk(clk), .rst(rst),
    .raw_in(raw_in), .raw_valid(raw_valid),
    .slope(slope_q), .cur_temp(cur_temp_q)
  );

  therm_guard_trip #(.TEMP_W(TEMP_W)) u_trip (
    .clk(clk), .rst(rst),
    .resp_en(resp_en_q), .cur_temp(cur_temp_q), .limit(limit_q),
    .shutdown_req(shutdown_req)
  );

endmodule

// File: rtl/therm_guard_checks.sv
module therm_guard_checks
  import therm_guard_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int RAW_W  = 12,
  parameter int TEMP_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              raw_valid,
  input logic              shutdown_req,
  input logic [TEMP_W-1:0] limit_q,
  input logic [DATA_W-1:0] slope_q,
  input logic              resp_en_q,
  input logic              guard_q,
  input logic [TEMP_W-1:0] cur_temp_q
);

  a_r4_guard_sticky: assert property (@(posedge clk) disable iff (rst)
    guard_q |=> guard_q);

  a_r5_limit_frozen: assert property (@(posedge clk) disable iff (rst)
    guard_q |=> $stable(limit_q));

  a_r5_slope_frozen: assert property (@(posedge clk) disable iff (rst)
    guard_q |=> $stable(slope_q));

  a_r5_resp_frozen: assert property (@(posedge clk) disable iff (rst)
    guard_q |=> $stable(resp_en_q));

  a_r7_temp_hold: assert property (@(posedge clk) disable iff (rst)
    !raw_valid |=> $stable(cur_temp_q));

  a_r9_trip_set: assert property (@(posedge clk) disable iff (rst)
    (resp_en_q && cur_temp_q >= limit_q) |=> shutdown_req);

  a_r9_trip_clear: assert property (@(posedge clk) disable iff (rst)
    !(resp_en_q && cur_temp_q >= limit_q) |=> !shutdown_req);

  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (decode_ofs(32'(bus_addr)) == SEL_NONE) |=> (bus_rdata == '0));

endmodule

bind therm_guard therm_guard_checks #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .RAW_W(RAW_W), .TEMP_W(TEMP_W)
) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .raw_valid(raw_valid), .shutdown_req(shutdown_req),
  .limit_q(limit_q), .slope_q(slope_q), .resp_en_q(resp_en_q),
  .guard_q(guard_q), .cur_temp_q(cur_temp_q)
);

// File: tb/therm_guard_bench.sv
module therm_guard_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [11:0] raw_in = '0;
  logic        raw_valid = 1'b0;
  logic        shutdown_req;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  therm_guard u_therm_guard (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .raw_in(raw_in), .raw_valid(raw_valid), .shutdown_req(shutdown_req)
  );

  localparam int NV = 9;
  localparam logic [31:0] V_SLOPE [NV] = '{32'd25, 32'd25, 32'd16, 32'd16,
    32'd16, 32'd1, 32'h10000, 32'd3, 32'd25};
  localparam logic [11:0] V_RAW [NV] = '{12'd10, 12'd0, 12'd200, 12'd255,
    12'd256, 12'd15, 12'd1, 12'd100, 12'd81};
  localparam logic [31:0] V_EXP [NV] = '{32'd15, 32'd0, 32'd200, 32'd255,
    32'd255, 32'd0, 32'd255, 32'd18, 32'd126};

  task automatic check(input string req, input logic [31:0] got,
                       input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  // All tasks start and end just after a falling edge.
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic sample(input logic [11:0] r);
    raw_in = r; raw_valid = 1'b1;
    @(negedge clk);
    raw_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    @(negedge clk);
    do_reset();

    // R1 reset values
    check("R1 shutdown_req", {31'd0, shutdown_req}, 32'd0);
    rd(8'h00, v); check("R1 limit", v, 32'd125);
    rd(8'h04, v); check("R1 slope", v, 32'd25);
    rd(8'h08, v); check("R1 guard", v, 32'd0);
    rd(8'h0C, v); check("R1 enable", v, 32'd0);
    rd(8'h10, v); check("R1 temp", v, 32'd0);

    // R2 limit field width, R11 read one cycle after write
    wr(8'h00, 32'hFFFF_FF5A);
    rd(8'h00, v); check("R2 R11 limit upper bits", v, 32'h5A);
    // R3 full slope
    wr(8'h04, 32'hDEAD_BEEF);
    rd(8'h04, v); check("R3 slope", v, 32'hDEAD_BEEF);
    // R9 enable field: only bit 1 stored
    wr(8'h0C, 32'hFFFF_FFFD);
    rd(8'h0C, v); check("R9 enable bit1 clear", v, 32'd0);
    wr(8'h0C, 32'hFFFF_FFFF);
    rd(8'h0C, v); check("R9 enable readback", v, 32'd2);
    wr(8'h0C, 32'd0);
    // R4 guard other bits
    wr(8'h08, 32'hFFFF_FFFE);
    rd(8'h08, v); check("R4 write 0 leaves guard", v, 32'd0);
    // R10 unmapped
    wr(8'h14, 32'h1234_5678);
    rd(8'h14, v); check("R10 unmapped read", v, 32'd0);
    rd(8'h02, v); check("R10 misaligned read", v, 32'd0);
    rd(8'h00, v); check("R10 no alias into limit", v, 32'h5A);
    // R8 temp read-only
    wr(8'h10, 32'hAB);
    rd(8'h10, v); check("R8 temp write ignored", v, 32'd0);

    // R7 conversion table
    for (int i = 0; i < NV; i++) begin
      wr(8'h04, V_SLOPE[i]);
      sample(V_RAW[i]);
      rd(8'h10, v);
      check($sformatf("R7 vector %0d", i), v, V_EXP[i]);
    end
    // R7 hold without valid
    raw_in = 12'd7;
    repeat (3) @(negedge clk);
    rd(8'h10, v); check("R7 hold", v, 32'd126);

    // R9 trip
    wr(8'h00, 32'd100);
    wr(8'h04, 32'd16);
    sample(12'd0);
    wr(8'h0C, 32'd2);
    @(negedge clk);
    check("R9 below", {31'd0, shutdown_req}, 32'd0);
    sample(12'd100);
    check("R9 one-cycle lag", {31'd0, shutdown_req}, 32'd0);
    @(negedge clk);
    check("R9 equal trips", {31'd0, shutdown_req}, 32'd1);
    sample(12'd99);
    @(negedge clk);
    check("R9 below clears", {31'd0, shutdown_req}, 32'd0);
    sample(12'd101);
    @(negedge clk);
    check("R9 above trips", {31'd0, shutdown_req}, 32'd1);
    wr(8'h0C, 32'd0);
    @(negedge clk);
    check("R9 disabled", {31'd0, shutdown_req}, 32'd0);
    wr(8'h0C, 32'd2);

    // R4 set guard, R6 immediate protected write
    wr(8'h08, 32'd1);
    wr(8'h00, 32'd50);
    rd(8'h00, v); check("R6 back-to-back limit write", v, 32'd100);
    wr(8'h04, 32'h55);
    wr(8'h0C, 32'd0);
    wr(8'h08, 32'd0);
    rd(8'h08, v); check("R4 guard sticky", v, 32'd1);
    rd(8'h04, v); check("R5 slope frozen", v, 32'd16);
    rd(8'h0C, v); check("R5 enable frozen", v, 32'd2);
    wr(8'h00, 32'd255);
    rd(8'h00, v); check("R5 limit frozen", v, 32'd100);
    sample(12'd120);
    @(negedge clk);
    check("R5 trip still active", {31'd0, shutdown_req}, 32'd1);
    rd(8'h10, v); check("R7 guarded conversion", v, 32'd120);

    // R4 only reset clears
    do_reset();
    rd(8'h08, v); check("R4 reset clears guard", v, 32'd0);
    rd(8'h00, v); check("R1 limit after reset", v, 32'd125);
    wr(8'h00, 32'd60);
    rd(8'h00, v); check("R4 writable after reset", v, 32'd60);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule